// File: doc/BRIEF.md
# Exception Escalation Controller

This block follows exception delivery in a small processor core. Each raised exception is sorted into one of three classes: benign, contributory or page fault. While an exception's handler is still being entered, a second exception is checked against the class of the first. Based on that pair, the block either delivers the second exception in turn or escalates to a double fault on vector 8. A further exception during double-fault entry stops the core in a shutdown state, and only reset leaves it.

The core strobes `raise_i` with a vector number when an exception occurs. It strobes `done_i` once the handler has been entered. The outputs are registered and show, one cycle later, which vector to deliver, whether an error code must be pushed and its value, and whether the core is in double-fault delivery or shutdown. Table lookup, stack writes, privilege checks and restart are left to the surrounding core.

States: IDLE (nothing being delivered), SERVE (an ordinary exception being delivered), DOUBLE (a double fault being delivered), HALT (shutdown). Transitions:
- IDLE→SERVE on a raise.
- SERVE→SERVE on a raise that does not escalate.
- SERVE→DOUBLE on a raise that escalates.
- DOUBLE→HALT on a raise.
- SERVE/DOUBLE→IDLE on completion.
- HALT→IDLE only through reset.

Top module: `exc_escalate`

## Requirements
- R1: While reset is held, and in the cycle after it is released, busy_o, double_o, halt_o and push_err_o are 0, and deliver_vec_o and err_code_o are 0.
- R2: A raise in IDLE leads to SERVE. From the next cycle, busy_o is 1 and deliver_vec_o equals the raised vector, with double_o and push_err_o at 0.
- R3: Vectors 0, 9, 10, 11, 12 and 13 are contributory. Vector 14 is the page-fault class. Every other vector, including 8, 15 and 17 to 31, counts as benign.
- R4: A contributory raise during SERVE of a contributory exception moves to DOUBLE. From the next cycle, double_o is 1 and deliver_vec_o is 8.
- R5: A contributory or page-fault raise during SERVE of a page fault moves to DOUBLE.
- R6: Every other pairing in SERVE is delivered in turn. deliver_vec_o becomes the new vector, and the new vector's class becomes the first class for any later raise.
- R7: In DOUBLE, push_err_o is 1 and err_code_o is 0.
- R8: A raise during DOUBLE moves to HALT. From the next cycle, halt_o is 1 and busy_o, double_o and deliver_vec_o are 0.
- R9: HALT ignores raise_i and done_i and persists until reset.
- R10: done_i in SERVE or DOUBLE returns the block to IDLE (busy_o 0 next cycle). The next raise is then treated as a first exception.
- R11: When raise_i and done_i come in the same cycle, completion takes effect first and the raise is judged from IDLE.
- R12: push_err_o is 0 in every state other than DOUBLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_i | input | 1 | Exception raised this cycle |
| raise_vec_i | input | 5 | Vector number of the raised exception |
| done_i | input | 1 | Handler entry finished this cycle |
| busy_o | output | 1 | Delivery in progress (SERVE or DOUBLE) |
| deliver_vec_o | output | 5 | Vector to deliver, 0 when not busy |
| push_err_o | output | 1 | An error code must be pushed |
| err_code_o | output | 32 | Error code value to push |
| double_o | output | 1 | Double fault being delivered |
| halt_o | output | 1 | Shutdown state |

## Verification
The hardest situation to reach is the class-update rule. It needs three raises in a row without any completion: a page fault during a contributory exception (delivered in turn), then a contributory raise that must now escalate because the first class has become page fault. The stimulus builds such chains of back-to-back raises. It also covers the same-cycle raise-with-completion case from both SERVE and DOUBLE, and it drives shutdown before and after a mid-run reset. A behavioural model predicts every output on every clock.

// File: rtl/exesc_pkg.sv
`timescale 1ns/1ps
package exesc_pkg;
    typedef enum logic [1:0] {
        CLS_BENIGN  = 2'd0,
        CLS_CONTRIB = 2'd1,
        CLS_PAGE    = 2'd2
    } exc_class_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SERVE  = 2'd1,
        ST_DOUBLE = 2'd2,
        ST_HALT   = 2'd3
    } esc_state_e;
endpackage

// File: rtl/exc_classify.sv
`timescale 1ns/1ps
module exc_classify
    import exesc_pkg::*;
#(
    parameter int VEC_W = 5,
    parameter logic [(2**VEC_W)-1:0] CONTRIB_MASK = 'h3E01,
    parameter int PAGE_VEC = 14
) (
    input  logic [VEC_W-1:0] vec_i,
    output exc_class_e       cls_o
);
    localparam int NVEC = 2**VEC_W;

    logic [NVEC-1:0] hit;

    // one decode line per vector number
    for (genvar g = 0; g < NVEC; g++) begin : g_dec
        assign hit[g] = (vec_i == g[VEC_W-1:0]);
    end

    always_comb begin
        if (vec_i == PAGE_VEC[VEC_W-1:0])
            cls_o = CLS_PAGE;
        else if (|(hit & CONTRIB_MASK))
            cls_o = CLS_CONTRIB;
        else
            cls_o = CLS_BENIGN;
    end
endmodule

// File: rtl/exc_esc_matrix.sv
`timescale 1ns/1ps
module exc_esc_matrix
    import exesc_pkg::*;
(
    input  exc_class_e first_i,
    input  exc_class_e second_i,
    output logic       escalate_o
);
    always_comb begin
        escalate_o = 1'b0;
        unique case (first_i)
            CLS_CONTRIB: escalate_o = (second_i == CLS_CONTRIB);
            CLS_PAGE:    escalate_o = (second_i == CLS_CONTRIB) || (second_i == CLS_PAGE);
            default:     escalate_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/exc_escalate.sv
`timescale 1ns/1ps
module exc_escalate
    import exesc_pkg::*;
#(
    parameter int VEC_W  = 5,
    parameter int CODE_W = 32,
    parameter int DF_VEC = 8,
    parameter int PF_VEC = 14,
    parameter logic [(2**VEC_W)-1:0] CONTRIB_MASK = 'h3E01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise_i,
    input  logic [VEC_W-1:0]  raise_vec_i,
    input  logic              done_i,
    output logic              busy_o,
    output logic [VEC_W-1:0]  deliver_vec_o,
    output logic              push_err_o,
    output logic [CODE_W-1:0] err_code_o,
    output logic              double_o,
    output logic              halt_o
);
    localparam logic [VEC_W-1:0] DF_CODE = DF_VEC[VEC_W-1:0];

    esc_state_e       state_q, state_d, base_st;
    logic [VEC_W-1:0] vec_q, vec_d;
    exc_class_e       cls_q, cls_d, raise_cls;
    logic             escalate;

    exc_classify #(
        .VEC_W(VEC_W), .CONTRIB_MASK(CONTRIB_MASK), .PAGE_VEC(PF_VEC)
    ) u_cls (
        .vec_i (raise_vec_i),
        .cls_o (raise_cls)
    );

    exc_esc_matrix u_mtx (
        .first_i    (cls_q),
        .second_i   (raise_cls),
        .escalate_o (escalate)
    );

    // next state: completion is applied before the raise is judged
    always_comb begin
        base_st = state_q;
        if (done_i && (state_q == ST_SERVE || state_q == ST_DOUBLE))
            base_st = ST_IDLE;
        state_d = base_st;
        vec_d   = vec_q;
        cls_d   = cls_q;
        unique case (base_st)
            ST_IDLE: begin
                if (raise_i) begin
                    state_d = ST_SERVE;
                    vec_d   = raise_vec_i;
                    cls_d   = raise_cls;
                end
            end
            ST_SERVE: begin
                if (raise_i) begin
                    if (escalate) begin
                        state_d = ST_DOUBLE;
                        vec_d   = DF_CODE;
                        cls_d   = CLS_CONTRIB;
                    end else begin
                        vec_d = raise_vec_i;
                        cls_d = raise_cls;
                    end
                end
            end
            ST_DOUBLE: begin
                if (raise_i)
                    state_d = ST_HALT;
            end
            ST_HALT: state_d = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
            cls_q   <= CLS_BENIGN;
        end else begin
            state_q <= state_d;
            vec_q   <= vec_d;
            cls_q   <= cls_d;
        end
    end

    // outputs from the registered state
    always_comb begin
        busy_o        = 1'b0;
        deliver_vec_o = '0;
        push_err_o    = 1'b0;
        err_code_o    = '0;
        double_o      = 1'b0;
        halt_o        = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SERVE: begin
                busy_o        = 1'b1;
                deliver_vec_o = vec_q;
            end
            ST_DOUBLE: begin
                busy_o        = 1'b1;
                deliver_vec_o = vec_q;
                double_o      = 1'b1;
                push_err_o    = 1'b1;
            end
            ST_HALT: halt_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/exc_escalate_chk.sv
`timescale 1ns/1ps
module exc_escalate_chk #(
    parameter int VEC_W  = 5,
    parameter int CODE_W = 32,
    parameter logic [(2**VEC_W)-1:0] CONTRIB_MASK = 'h3E01
) (
    input logic              clk,
    input logic              rst_n,
    input logic              raise_i,
    input logic [VEC_W-1:0]  raise_vec_i,
    input logic              done_i,
    input logic              busy_o,
    input logic [VEC_W-1:0]  deliver_vec_o,
    input logic              push_err_o,
    input logic [CODE_W-1:0] err_code_o,
    input logic              double_o,
    input logic              halt_o
);
    logic both_contrib;
    assign both_contrib = CONTRIB_MASK[deliver_vec_o] && CONTRIB_MASK[raise_vec_i];

    // R4
    contrib_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !double_o && both_contrib && raise_i && !done_i)
        |=> (double_o && deliver_vec_o == VEC_W'(8)));

    // R7
    df_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        double_o |-> (push_err_o && err_code_o == '0));

    // R8
    df_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (double_o && raise_i && !done_i) |=> (halt_o && !busy_o));

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> halt_o);

    // R2
    first_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !halt_o && raise_i) |=> (busy_o && deliver_vec_o == $past(raise_vec_i)));

    // R10
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && done_i && !raise_i) |=> !busy_o);

    // R12
    push_only_df_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_err_o |-> double_o);

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({halt_o, busy_o}));
endmodule

bind exc_escalate exc_escalate_chk #(
    .VEC_W(VEC_W), .CODE_W(CODE_W), .CONTRIB_MASK(CONTRIB_MASK)
) u_chk (.*);

// File: tb/tb_exc_escalate.sv
`timescale 1ns/1ps
module tb_exc_escalate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raise_i = 1'b0;
    logic [4:0]  raise_vec_i = '0;
    logic        done_i = 1'b0;
    logic        busy_o, push_err_o, double_o, halt_o;
    logic [4:0]  deliver_vec_o;
    logic [31:0] err_code_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model: 0 idle, 1 serve, 2 double, 3 halt
    int m_st = 0, m_vec = 0, m_cls = 0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    exc_escalate dut (
        .clk, .rst_n, .raise_i, .raise_vec_i, .done_i,
        .busy_o, .deliver_vec_o, .push_err_o, .err_code_o, .double_o, .halt_o
    );

    // R3: 0 = benign, 1 = contributory, 2 = page fault
    function automatic int cls_of(int v);
        if (v == 14) return 2;
        if (v == 0 || (v >= 9 && v <= 13)) return 1;
        return 0;
    endfunction

    function automatic void model(bit r, int v, bit d);
        int c;
        c = cls_of(v);
        if (m_st == 3) return;
        if (d && (m_st == 1 || m_st == 2)) m_st = 0;
        if (!r) return;
        case (m_st)
            0: begin m_st = 1; m_vec = v; m_cls = c; end
            1: begin
                if ((m_cls == 1 && c == 1) || (m_cls == 2 && (c == 1 || c == 2))) begin
                    m_st = 2; m_vec = 8; m_cls = 1;
                end else begin
                    m_vec = v; m_cls = c;
                end
            end
            2: m_st = 3;
            default: ;
        endcase
    endfunction

    task automatic compare();
        logic [43:0] act, exp;
        bit eb;
        eb  = (m_st == 1 || m_st == 2);
        exp = {eb, eb ? 5'(m_vec) : 5'd0, m_st == 2, 32'd0, m_st == 2, m_st == 3};
        act = {busy_o, deliver_vec_o, push_err_o, err_code_o, double_o, halt_o};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act busy=%0b vec=%0d push=%0b code=%0h dbl=%0b halt=%0b exp busy=%0b vec=%0d push=%0b code=0 dbl=%0b halt=%0b",
                cur_tag, busy_o, deliver_vec_o, push_err_o, err_code_o, double_o, halt_o,
                eb, eb ? m_vec : 0, m_st == 2, m_st == 2, m_st == 3);
        end
    endtask

    task automatic step(input bit r, input int v, input bit d, input string tag);
        @(negedge clk);
        compare();
        raise_i = r; raise_vec_i = 5'(v); done_i = d;
        if (rst_n) model(r, v, d);
        cur_tag = tag;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; raise_i = 1'b0; done_i = 1'b0;
        m_st = 0; m_vec = 0; m_cls = 0; cur_tag = "R1";
        repeat (2) begin @(negedge clk); compare(); end
        rst_n = 1'b1;
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, tag);
    endtask

    initial begin
        do_reset();
        idle("R1");
        // R2 and R10: benign first exception, then completion
        step(1, 6, 0, "R2");
        idle("R2");
        step(0, 0, 1, "R10");
        idle("R10");
        // R4 and R7: contributory on contributory
        step(1, 13, 0, "R2");
        step(1, 0, 0, "R4");
        idle("R7");
        step(0, 0, 1, "R10");
        // R5: contributory and page fault on page fault
        step(1, 14, 0, "R2");
        step(1, 11, 0, "R5");
        step(0, 0, 1, "R10");
        step(1, 14, 0, "R2");
        step(1, 14, 0, "R5");
        step(0, 0, 1, "R10");
        // R6: page fault on contributory is serial, then class update escalates
        step(1, 13, 0, "R2");
        step(1, 14, 0, "R6");
        step(1, 12, 0, "R6");
        step(0, 0, 1, "R10");
        // R6: contributory on benign is serial, then escalates on next contributory
        step(1, 1, 0, "R2");
        step(1, 0, 0, "R6");
        step(1, 0, 0, "R4");
        step(0, 0, 1, "R10");
        // R3: unlisted vectors are benign
        step(1, 8, 0, "R3");
        step(1, 10, 0, "R3");
        step(1, 20, 0, "R6");
        step(1, 9, 0, "R3");
        step(1, 16, 0, "R3");
        step(1, 31, 0, "R3");
        step(0, 0, 1, "R10");
        // R10: after completion a contributory raise is a first exception
        step(1, 13, 0, "R2");
        step(0, 0, 1, "R10");
        step(1, 13, 0, "R10");
        // R11: raise and completion together from SERVE
        step(1, 12, 1, "R11");
        idle("R11");
        // R11: from DOUBLE
        step(1, 11, 0, "R4");
        step(1, 10, 1, "R11");
        idle("R12");
        step(0, 0, 1, "R10");
        // R8 and R9: shutdown
        step(1, 13, 0, "R2");
        step(1, 13, 0, "R4");
        step(1, 3, 0, "R8");
        step(1, 14, 0, "R9");
        step(0, 0, 1, "R9");
        step(1, 0, 1, "R9");
        idle("R9");
        // R1 and R9: only reset leaves shutdown
        do_reset();
        idle("R1");
        step(1, 5, 0, "R9");
        idle("R12");
        repeat (50) begin
            step(1, 14, 0, "R5");
            step(1, 0, 0, "R5");
            step(0, 0, 1, "R10");
        end
        idle("R10");
        @(negedge clk);
        compare();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule